// File: doc/BRIEF.md
# Two-Bank Cartridge Dump Sequencer

This block drives the bus while a cartridge image is read out. After a `start` pulse it reads up to four signature bytes from fixed header offsets. From them it decides whether the cartridge holds two switchable banks. If it does, the block keeps the two bank-select values, works out the total image size, and runs a full dump in order. It selects bank 0 and streams the lower half. It then selects bank 1 and streams the upper half. Last, it puts bank 0 back. If the cartridge does not hold two banks, it raises `single_pack` so that the ordinary size probe can run instead, and it touches nothing else.

Reads use a plain request/acknowledge byte port: `rd_req` and `rd_addr` are held until `rd_ack` returns the byte. A bank select is a write of the stored value to the bank register at 0xFFFF. The block raises `wr_stb` for exactly `STROBE_CYC` clock cycles; the default is 92 cycles, about 736 ns at 125 MHz. Dumped bytes leave on a valid/ready stream that carries the source address of each byte. A byte moves only in a cycle where `out_valid` and `out_ready` are both high. While the block waits for the sink, it holds `out_valid`, `out_addr`, `out_data` and `out_last` steady. It never drops a byte and never starts the next bus read before the current byte is taken. Storage of the stream is outside the block.

`MIB_LOG2` sets the size unit: one "MiB" is 2^MIB_LOG2 bytes, and the default of 20 gives true megabytes. The upper half starts at 2 units.

Top module: `mp_bank_dumper`

## Requirements
- R1: Header bytes are read in the order 0x3FFC, 0x3FFD, 0x3FFB, 0x3FFF. Reading stops at the first byte that rules out a two-bank cartridge, so the read count is 1 to 4.
- R2: The cartridge is two-bank (`multi_pack`=1) only when 0x3FFC≠0, 0x3FFD≠0, 0x3FFB=0 and 0x3FFF=0. Otherwise the block sets `single_pack`=1 and `done`=1. In that case `size_bytes` is 0, and there are no bank writes and no stream bytes.
- R3: On a two-bank cartridge, `bank0_sel` shows the byte read from 0x3FFC and `bank1_sel` shows the byte read from 0x3FFD.
- R4: The size is decided from the pair (bank 0 value, bank 1 value):
  - 0x28/0x2E gives a size of 2 units with `size_warn`=0.
  - 0x20/0x31 gives 4 units with `size_warn`=0.
  - Any other pair gives 4 units with `size_warn`=1.
- R5: Every bank select holds `wr_stb` high for exactly `STROBE_CYC` consecutive cycles, with `wr_addr`=0xFFFF and `wr_data` equal to the select value.
- R6: A two-bank dump runs in this order:
  1. Write the bank 0 value.
  2. Read size/2 bytes from address 0 upward.
  3. Write the bank 1 value.
  4. Read size/2 bytes from 2 units upward.
  5. Write the bank 0 value again.
  6. Set `done`.
- R7: Each stream byte carries the data the bus returned for `out_addr`. Under back-pressure `out_valid`, `out_addr`, `out_data` and `out_last` stay steady until the byte is taken.
- R8: `out_last` is 1 only on the final byte of the upper half.
- R9: `wr_stb` is never high in the same cycle as `rd_req` or `out_valid`, and `rd_req` is never high while `out_valid` is high.
- R10: After reset the outputs are as follows:
  - `busy`, `done`, the flags, `rd_req`, `wr_stb` and `out_valid` are all 0.
  - `busy` is 1 from the cycle after `start` until the run ends.
  - `done` stays 1 until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin detection and dump (sampled when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| single_pack | output | 1 | Not a two-bank cartridge; run the ordinary size probe |
| multi_pack | output | 1 | Two-bank cartridge detected |
| size_warn | output | 1 | Unknown select pair, size defaulted to 4 units |
| size_bytes | output | ADDR_W+1 | Total image size in bytes (0 if single) |
| bank0_sel | output | 8 | Recorded bank 0 select value |
| bank1_sel | output | 8 | Recorded bank 1 select value |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read data valid, one cycle |
| rd_data | input | 8 | Read data |
| wr_stb | output | 1 | Bank register write strobe |
| wr_addr | output | ADDR_W | Write address (bank register) |
| wr_data | output | 8 | Write data (select value) |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_addr | output | ADDR_W | Source address of the byte |
| out_data | output | 8 | Dumped byte |
| out_last | output | 1 | Final byte of the dump |

## Verification
The final byte of a half can be waiting on the stream while the next bank select is due. If the select were allowed to start in that cycle, the pending byte would be read under the wrong bank, or the strobe would overlap a live byte. The bench provokes this case with a sink that drops `out_ready` for fifteen of every sixteen cycles, so the last lower-half byte sits stalled across many cycles. The bench models a cartridge whose data depends on the bank value most recently written. It then judges the case three ways: each byte's value must match its expected bank, the byte must stay steady while stalled, and `wr_stb` must stay low while `out_valid` is high.

// File: rtl/mp_pkg.sv
package mp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_BANKWR,
    ST_DREAD,
    ST_DSEND
  } mp_state_t;

  typedef enum logic [1:0] {
    PH_LOW,
    PH_HIGH,
    PH_RESTORE
  } mp_phase_t;

  // Fixed header offsets, in read order, and the bank register.
  localparam logic [15:0] HDR_A0   = 16'h3FFC;
  localparam logic [15:0] HDR_A1   = 16'h3FFD;
  localparam logic [15:0] HDR_A2   = 16'h3FFB;
  localparam logic [15:0] HDR_A3   = 16'h3FFF;
  localparam logic [15:0] BANK_REG = 16'hFFFF;

  // Known select pairs.
  localparam logic [7:0] PAIR2_LO = 8'h28;
  localparam logic [7:0] PAIR2_HI = 8'h2E;
  localparam logic [7:0] PAIR4_LO = 8'h20;
  localparam logic [7:0] PAIR4_HI = 8'h31;

endpackage

// File: rtl/mp_hdr_check.sv
module mp_hdr_check
  import mp_pkg::*;
(
  input  logic [1:0]  idx,
  input  logic [7:0]  hbyte,
  output logic [15:0] haddr,
  output logic        reject
);
  always_comb begin
    unique case (idx)
      2'd0: begin haddr = HDR_A0; reject = (hbyte == 8'h00); end
      2'd1: begin haddr = HDR_A1; reject = (hbyte == 8'h00); end
      2'd2: begin haddr = HDR_A2; reject = (hbyte != 8'h00); end
      default: begin haddr = HDR_A3; reject = (hbyte != 8'h00); end
    endcase
  end
endmodule

// File: rtl/mp_pair_decode.sv
module mp_pair_decode
  import mp_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int MIB_LOG2 = 20
) (
  input  logic [7:0]      sel0,
  input  logic [7:0]      sel1,
  output logic [ADDR_W:0] size_bytes,
  output logic            warn
);
  localparam logic [ADDR_W:0] SZ_TWO  = (ADDR_W+1)'(1) << (MIB_LOG2 + 1);
  localparam logic [ADDR_W:0] SZ_FOUR = (ADDR_W+1)'(1) << (MIB_LOG2 + 2);

  logic is_two, is_four;

  always_comb begin
    is_two     = (sel0 == PAIR2_LO) && (sel1 == PAIR2_HI);
    is_four    = (sel0 == PAIR4_LO) && (sel1 == PAIR4_HI);
    warn       = !(is_two || is_four);
    size_bytes = is_two ? SZ_TWO : SZ_FOUR;
  end
endmodule

// File: rtl/mp_strobe_timer.sv
module mp_strobe_timer #(
  parameter int STROBE_CYC = 92
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic ending
);
  localparam int CW = $clog2(STROBE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (fire)            cnt_q <= CW'(STROBE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign active = (cnt_q != '0);
  assign ending = (cnt_q == CW'(1));
endmodule

// File: rtl/mp_dump_ctr.sv
module mp_dump_ctr #(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   count,
  input  logic              step,
  output logic [ADDR_W-1:0] cur,
  output logic              final_one
);
  logic [ADDR_W:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      left_q <= '0;
    end else if (load) begin
      cur    <= base;
      left_q <= count;
    end else if (step) begin
      cur    <= cur + ADDR_W'(1);
      left_q <= left_q - (ADDR_W+1)'(1);
    end
  end

  assign final_one = (left_q == (ADDR_W+1)'(1));
endmodule

// File: rtl/mp_bank_dumper.sv
module mp_bank_dumper
  import mp_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int MIB_LOG2   = 20,
  parameter int STROBE_CYC = 92
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              single_pack,
  output logic              multi_pack,
  output logic              size_warn,
  output logic [ADDR_W:0]   size_bytes,
  output logic [7:0]        bank0_sel,
  output logic [7:0]        bank1_sel,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam logic [ADDR_W-1:0] UPPER_BASE = ADDR_W'(1) << (MIB_LOG2 + 1);
  localparam logic [ADDR_W-1:0] BANK_ADDR  = {{(ADDR_W-16){1'b0}}, BANK_REG};

  mp_state_t state_q;
  mp_phase_t phase_q;
  logic [1:0] hidx_q;

  logic [15:0]       haddr;
  logic              hreject;
  logic [ADDR_W:0]   dec_size;
  logic              dec_warn;
  logic              tmr_fire, tmr_end;
  logic              ctr_load, ctr_step, ctr_final;
  logic [ADDR_W-1:0] ctr_cur;
  logic [ADDR_W-1:0] ctr_base;
  logic              accept;

  mp_hdr_check u_hdr (
    .idx(hidx_q), .hbyte(rd_data), .haddr(haddr), .reject(hreject)
  );

  mp_pair_decode #(.ADDR_W(ADDR_W), .MIB_LOG2(MIB_LOG2)) u_dec (
    .sel0(bank0_sel), .sel1(bank1_sel), .size_bytes(dec_size), .warn(dec_warn)
  );

  mp_strobe_timer #(.STROBE_CYC(STROBE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .fire(tmr_fire), .active(wr_stb), .ending(tmr_end)
  );

  mp_dump_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .base(ctr_base),
    .count(size_bytes >> 1), .step(ctr_step), .cur(ctr_cur), .final_one(ctr_final)
  );

  assign accept   = (state_q == ST_DSEND) && out_ready;
  assign ctr_base = (phase_q == PH_HIGH) ? UPPER_BASE : '0;
  assign ctr_load = (state_q == ST_BANKWR) && tmr_end && (phase_q != PH_RESTORE);
  assign ctr_step = accept && !ctr_final;

  always_comb begin
    tmr_fire = 1'b0;
    if (state_q == ST_HDR && rd_ack && !hreject && hidx_q == 2'd3) tmr_fire = 1'b1;
    if (accept && ctr_final) tmr_fire = 1'b1;
  end

  assign busy      = (state_q != ST_IDLE);
  assign rd_req    = (state_q == ST_HDR) || (state_q == ST_DREAD);
  assign rd_addr   = (state_q == ST_HDR) ? {{(ADDR_W-16){1'b0}}, haddr} : ctr_cur;
  assign wr_addr   = BANK_ADDR;
  assign wr_data   = (phase_q == PH_HIGH) ? bank1_sel : bank0_sel;
  assign out_valid = (state_q == ST_DSEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_LOW;
      hidx_q      <= 2'd0;
      done        <= 1'b0;
      single_pack <= 1'b0;
      multi_pack  <= 1'b0;
      size_warn   <= 1'b0;
      size_bytes  <= '0;
      bank0_sel   <= 8'h00;
      bank1_sel   <= 8'h00;
      out_addr    <= '0;
      out_data    <= 8'h00;
      out_last    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            done        <= 1'b0;
            single_pack <= 1'b0;
            multi_pack  <= 1'b0;
            size_warn   <= 1'b0;
            size_bytes  <= '0;
            hidx_q      <= 2'd0;
            state_q     <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (rd_ack) begin
            if (hidx_q == 2'd0) bank0_sel <= rd_data;
            if (hidx_q == 2'd1) bank1_sel <= rd_data;
            if (hreject) begin
              single_pack <= 1'b1;
              done        <= 1'b1;
              state_q     <= ST_IDLE;
            end else if (hidx_q == 2'd3) begin
              multi_pack <= 1'b1;
              size_bytes <= dec_size;
              size_warn  <= dec_warn;
              phase_q    <= PH_LOW;
              state_q    <= ST_BANKWR;
            end else begin
              hidx_q <= hidx_q + 2'd1;
            end
          end
        end
        ST_BANKWR: begin
          if (tmr_end) begin
            if (phase_q == PH_RESTORE) begin
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DREAD;
            end
          end
        end
        ST_DREAD: begin
          if (rd_ack) begin
            out_addr <= ctr_cur;
            out_data <= rd_data;
            out_last <= (phase_q == PH_HIGH) && ctr_final;
            state_q  <= ST_DSEND;
          end
        end
        ST_DSEND: begin
          if (out_ready) begin
            out_last <= 1'b0;
            if (ctr_final) begin
              phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_RESTORE;
              state_q <= ST_BANKWR;
            end else begin
              state_q <= ST_DREAD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mp_bank_dumper_chk.sv
module mp_bank_dumper_chk #(
  parameter int ADDR_W     = 22,
  parameter int STROBE_CYC = 92
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              single_pack,
  input logic              multi_pack,
  input logic              rd_req,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [7:0]        out_data,
  input logic              out_last
);
  localparam int CW = $clog2(STROBE_CYC + 2) + 1;

  logic          stb_q;
  logic [CW-1:0] stb_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      stb_len <= '0;
    end else begin
      stb_q <= wr_stb;
      if (wr_stb) stb_len <= stb_q ? stb_len + CW'(1) : CW'(1);
    end
  end

  // R5
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !wr_stb) |-> (stb_len == CW'(STROBE_CYC)));

  // R5
  strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr == ADDR_W'(16'hFFFF)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr) && $stable(out_last)));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (!out_valid && !rd_req));

  // R9
  rd_vs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !out_valid);

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_pack && multi_pack));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind mp_bank_dumper mp_bank_dumper_chk #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .single_pack(single_pack),
  .multi_pack(multi_pack), .rd_req(rd_req), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/tb_mp_bank_dumper.sv
module tb_mp_bank_dumper;
  localparam int AW   = 22;
  localparam int MIB  = 4;
  localparam int SCYC = 92;
  localparam int UB   = 1 << (MIB + 1);

  // {s0, s1, b3ffb, b3fff, exp_reads[3:0], {multi,warn,big,0}, ready_mode[3:0]}
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {8'h28, 8'h2E, 8'h00, 8'h00, 4'd4, 4'b1000, 4'd0},
    {8'h20, 8'h31, 8'h00, 8'h00, 4'd4, 4'b1010, 4'd1},
    {8'h12, 8'h34, 8'h00, 8'h00, 4'd4, 4'b1110, 4'd2},
    {8'h00, 8'h2E, 8'h00, 8'h00, 4'd1, 4'b0000, 4'd0},
    {8'h28, 8'h00, 8'h00, 8'h00, 4'd2, 4'b0000, 4'd1},
    {8'h28, 8'h2E, 8'h01, 8'h00, 4'd3, 4'b0000, 4'd0},
    {8'h28, 8'h2E, 8'h00, 8'hFF, 4'd4, 4'b0000, 4'd2},
    {8'h2E, 8'h28, 8'h00, 8'h00, 4'd4, 4'b1110, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, single_pack, multi_pack, size_warn;
  logic [AW:0] size_bytes;
  logic [7:0] bank0_sel, bank1_sel;
  logic rd_req, rd_ack;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic wr_stb;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic out_valid, out_ready, out_last;
  logic [AW-1:0] out_addr;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  mp_bank_dumper #(.ADDR_W(AW), .MIB_LOG2(MIB), .STROBE_CYC(SCYC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .single_pack(single_pack), .multi_pack(multi_pack), .size_warn(size_warn),
    .size_bytes(size_bytes), .bank0_sel(bank0_sel), .bank1_sel(bank1_sel),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_last(out_last)
  );

  int n_chk = 0;
  int n_bad = 0;

  // stimulus state, written by the test process only
  logic [7:0] h_s0, h_s1, h_b, h_f;
  int rmode = 0;
  int exp_half = 0;
  int hbase = 0, wbase = 0, sbase = 0;

  // monitor state
  logic [7:0] bank_reg;
  int lat_cnt;
  int hcnt, hord_err;
  int wcnt, slen, slen_err, ovl_err;
  logic [7:0] wlog [16];
  logic prev_stb;
  int scnt, s_err, hold_err, rc;
  logic hold_f;
  logic [AW-1:0] hold_a;
  logic [7:0] hold_d;
  logic hold_l;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [AW-1:0] a);
    case (a)
      AW'(16'h3FFC): return h_s0;
      AW'(16'h3FFD): return h_s1;
      AW'(16'h3FFB): return h_b;
      AW'(16'h3FFF): return h_f;
      default:       return a[7:0] ^ bank_reg ^ 8'h5A;
    endcase
  endfunction

  function automatic logic [AW-1:0] hdr_at(input int k);
    case (k)
      0: return AW'(16'h3FFC);
      1: return AW'(16'h3FFD);
      2: return AW'(16'h3FFB);
      default: return AW'(16'h3FFF);
    endcase
  endfunction

  // bus read model with mode-dependent latency; logs header read order (R1)
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 1'b0; rd_data = 8'h00; lat_cnt = 0; hcnt = 0; hord_err = 0;
    end else if (rd_ack) begin
      rd_ack = 1'b0;
    end else if (rd_req) begin
      if (lat_cnt >= rmode) begin
        rd_ack = 1'b1;
        rd_data = model(rd_addr);
        lat_cnt = 0;
        if (rd_addr >= AW'(16'h3FF0)) begin
          if (rd_addr != hdr_at(hcnt - hbase)) hord_err++;
          hcnt++;
        end
      end else lat_cnt++;
    end
  end

  // bank write monitor (R5, R9)
  always @(negedge clk) begin
    if (!rst_n) begin
      wcnt = 0; slen = 0; slen_err = 0; ovl_err = 0; prev_stb = 1'b0; bank_reg = 8'h00;
    end else begin
      if (wr_stb && !prev_stb) begin
        wlog[wcnt % 16] = wr_data;
        bank_reg = wr_data;
        wcnt++;
        slen = 1;
        if (wr_addr != AW'(16'hFFFF)) slen_err++;
      end else if (wr_stb) slen++;
      if (!wr_stb && prev_stb && slen != SCYC) slen_err++;
      if (wr_stb && (out_valid || rd_req)) ovl_err++;
      prev_stb = wr_stb;
    end
  end

  // stream sink: drives out_ready and checks each accepted byte (R6, R7, R8)
  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 1'b0; scnt = 0; s_err = 0; hold_err = 0; rc = 0; hold_f = 1'b0;
      hold_a = '0; hold_d = 8'h00; hold_l = 1'b0;
    end else begin
      if (hold_f && !(out_valid && out_addr == hold_a && out_data == hold_d && out_last == hold_l))
        hold_err++;
      rc++;
      case (rmode)
        1: out_ready = rc[0] ^ rc[2];
        2: out_ready = (rc[3:0] == 4'd0);
        default: out_ready = 1'b1;
      endcase
      if (out_valid && out_ready) begin
        int k;
        logic [AW-1:0] ea;
        logic [7:0] eb;
        k  = scnt - sbase;
        ea = (k < exp_half) ? AW'(k) : AW'(UB + k - exp_half);
        eb = (k < exp_half) ? h_s0 : h_s1;
        if (out_addr != ea || out_data != (ea[7:0] ^ eb ^ 8'h5A) ||
            out_last != (k == 2 * exp_half - 1)) s_err++;
        scnt++;
      end
      hold_f = out_valid && !out_ready;
      hold_a = out_addr; hold_d = out_data; hold_l = out_last;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    h_s0 = 8'h00; h_s1 = 8'h00; h_b = 8'h00; h_f = 8'h00;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !rd_req && !wr_stb && !out_valid, "R10 reset outputs",
        {busy, done, rd_req, wr_stb, out_valid}, 0);
    chk(!single_pack && !multi_pack && !size_warn, "R10 reset flags",
        {single_pack, multi_pack, size_warn}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      bit em, ew, eb4;
      int hr0, wr0, sr0, so0, ov0, sl0, ho0;
      v = VEC[i];
      h_s0 = v[43:36]; h_s1 = v[35:28]; h_b = v[27:20]; h_f = v[19:12];
      em = v[7]; ew = v[6]; eb4 = v[5];
      rmode = int'(v[3:0]);
      exp_half = em ? (eb4 ? UB : UB / 2) : 0;
      hbase = hcnt; wbase = wcnt; sbase = scnt;
      hr0 = hord_err; wr0 = wcnt; sr0 = scnt; so0 = s_err; ov0 = ovl_err; sl0 = slen_err; ho0 = hold_err;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R10 busy after start", busy, 1);
      while (!done) @(negedge clk);
      // R1 header order and early stop
      chk(hcnt - hbase == int'(v[11:8]), "R1 header read count", hcnt - hbase, v[11:8]);
      chk(hord_err == hr0, "R1 header read order", hord_err - hr0, 0);
      // R2 classification
      chk(multi_pack == em && single_pack == !em, "R2 multi/single flags",
          {multi_pack, single_pack}, {em, !em});
      // R4 size and warning
      chk(size_bytes == (AW+1)'(2 * exp_half), "R4 size", size_bytes, 2 * exp_half);
      if (em) chk(size_warn == ew, "R4 warn", size_warn, ew);
      // R3 recorded selectors
      if (em) chk(bank0_sel == h_s0 && bank1_sel == h_s1, "R3 selectors",
                  {bank0_sel, bank1_sel}, {h_s0, h_s1});
      // R2 / R6 bank write count and values
      chk(wcnt - wr0 == (em ? 3 : 0), "R6 bank write count", wcnt - wr0, em ? 3 : 0);
      if (em) chk(wlog[wbase % 16] == h_s0 && wlog[(wbase + 1) % 16] == h_s1 &&
                  wlog[(wbase + 2) % 16] == h_s0, "R6 bank write sequence",
                  {wlog[wbase % 16], wlog[(wbase + 1) % 16], wlog[(wbase + 2) % 16]},
                  {h_s0, h_s1, h_s0});
      // R6 stream length, R7/R8 content
      chk(scnt - sr0 == 2 * exp_half, "R6 stream byte count", scnt - sr0, 2 * exp_half);
      chk(s_err == so0, "R7 R8 stream content/last", s_err - so0, 0);
      chk(hold_err == ho0, "R7 stall stability", hold_err - ho0, 0);
      chk(slen_err == sl0, "R5 strobe length/addr", slen_err - sl0, 0);
      chk(ovl_err == ov0, "R9 strobe overlap", ovl_err - ov0, 0);
      repeat (5) @(negedge clk);
      chk(done && !busy, "R10 done held", {done, busy}, 2'b10);
    end

    // R10 reset in the middle of a dump
    h_s0 = 8'h28; h_s1 = 8'h2E; h_b = 8'h00; h_f = 8'h00; rmode = 0; exp_half = UB / 2;
    hbase = hcnt; wbase = wcnt; sbase = scnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (scnt - sbase < 5) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_req && !wr_stb && !out_valid, "R10 mid-run reset outputs",
        {busy, done, rd_req, wr_stb, out_valid}, 0);
    chk(!multi_pack && !single_pack && size_bytes == '0, "R10 mid-run reset flags",
        {multi_pack, single_pack}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule